// File: doc/BRIEF.md
# Three-Level Hit Latch and Encoder

This block captures the state of a bank of channels. Each channel has three comparator levels: low, medium and high. Every level of every channel has its own sticky latch. The latch sets when its comparator input is high and its enable mask is clear. Once set, it holds until a channel clear is applied. The three latches of a channel are reduced to a 2-bit code that names the highest level reached.

The block also drives three fast trigger outputs, one per level. Each trigger is the OR, across all channels, of that level's masked comparator input. A trigger follows its inputs in the same cycle, without waiting for a clock edge.

An event-valid strobe copies the whole packed code word into a holding register. Downstream readout then sees a stable snapshot while the live latches keep collecting or are cleared for the next event.

Top module: `hit_latch_encoder`

## Requirements
- R1: While `rst_n` is low at a clock edge, every latch and the holding register are cleared, so `hit_code_o` and `held_code_o` read all zeros afterwards.
- R2: A level latch sets on the first rising clock edge at which its comparator input is high and its mask bit is 0. It stays set after the input falls, until a channel clear.
- R3: A level whose mask bit is 1 never sets its latch, whatever its comparator input does.
- R4: A level whose mask bit is 1 contributes nothing to its trigger output.
- R5: `trig_lo_o`, `trig_mid_o` and `trig_hi_o` are each, combinationally in the same cycle, the OR over all channels of (comparator input AND NOT mask) for that level.
- R6: Channel c's code sits at bits [2c+1:2c] of `hit_code_o` and reports the highest latched level. A high latch gives 2'b11. Otherwise a medium latch gives 2'b10. Otherwise a low latch gives 2'b01. With no latch set the code is 2'b00. A lone medium or lone high hit is encoded by its own level.
- R7: At a rising edge where `chan_clr_i` is 1, every latch is cleared. This clear wins over any comparator input that is high in the same cycle.
- R8: At a rising edge where `evt_valid_i` is 1, `held_code_o` takes the value `hit_code_o` had just before that edge.
- R9: At a rising edge where `evt_valid_i` is 0, `held_code_o` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| disc_lo_i | input | N_CH | Low-level comparator inputs, one per channel |
| disc_mid_i | input | N_CH | Medium-level comparator inputs |
| disc_hi_i | input | N_CH | High-level comparator inputs |
| mask_lo_i | input | N_CH | 1 disables the channel's low level |
| mask_mid_i | input | N_CH | 1 disables the channel's medium level |
| mask_hi_i | input | N_CH | 1 disables the channel's high level |
| chan_clr_i | input | 1 | Clears all level latches at the next edge |
| evt_valid_i | input | 1 | Loads the holding register at the next edge |
| trig_lo_o | output | 1 | OR of masked low-level inputs |
| trig_mid_o | output | 1 | OR of masked medium-level inputs |
| trig_hi_o | output | 1 | OR of masked high-level inputs |
| hit_code_o | output | 2*N_CH | Live per-channel codes, channel c at [2c+1:2c] |
| held_code_o | output | 2*N_CH | Snapshot of the codes taken on event valid |

## Verification
The hardest situation to reach is a collision of controls in one cycle. It occurs when a channel clear, an event-valid strobe and fresh comparator hits all arrive together. The snapshot must then hold the pre-clear codes, and the latches must come out empty. Directed steps create this case at several code values. A long random phase then keeps clears and strobes frequent while comparator hits stay sparse, so such overlaps recur with partially filled latches. A behavioural per-channel model checks every output on every cycle.

// File: rtl/hle_pkg.sv
// Shared constants and types for the three-level hit latch and encoder.
package hle_pkg;
    localparam int NUM_LVL = 3;
    localparam int CODE_W  = 2;

    typedef enum logic [CODE_W-1:0] {
        HIT_NONE = 2'b00,
        HIT_LOW  = 2'b01,
        HIT_MID  = 2'b10,
        HIT_HIGH = 2'b11
    } hit_code_e;

    // One bit per level of one channel.
    typedef struct packed {
        logic hi;
        logic mid;
        logic lo;
    } lvl_t;
endpackage

// File: rtl/hle_chan.sv
// One channel: masks the three comparator levels, keeps a sticky latch per
// level and encodes the highest latched level into a 2-bit code.
// Assumes comparator inputs are already synchronous to clk.
module hle_chan
    import hle_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  lvl_t              disc,
    input  lvl_t              mask,
    output lvl_t              armed,
    output logic [CODE_W-1:0] code
);
    lvl_t seen_q;

    // Gate each comparator level by its enable mask.
    always_comb armed = lvl_t'(disc & ~mask);

    // Sticky level latches; clear wins over a new hit.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) seen_q <= '0;
        else               seen_q <= lvl_t'(seen_q | armed);
    end

    // Report the highest latched level.
    always_comb begin
        if (seen_q.hi)       code = HIT_HIGH;
        else if (seen_q.mid) code = HIT_MID;
        else if (seen_q.lo)  code = HIT_LOW;
        else                 code = HIT_NONE;
    end
endmodule

// File: rtl/hle_or_tree.sv
// Wide OR reduction used for one trigger level. Purely combinational.
module hle_or_tree #(
    parameter int WIDTH = 64
) (
    input  logic [WIDTH-1:0] bits,
    output logic             any
);
    // Reduce all inputs to one flag.
    always_comb any = |bits;
endmodule

// File: rtl/hle_hold.sv
// Holding register: loads a word when load is high, otherwise keeps it.
// Assumes synchronous active-low reset.
module hle_hold #(
    parameter int W = 128
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Snapshot on load, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= d;
    end
endmodule

// File: rtl/hit_latch_encoder.sv
// Top level: N_CH channels of three-level sticky latches with 2-bit codes,
// three combinational OR triggers and an event-validated snapshot register.
// Assumes all inputs are synchronous to clk.
module hit_latch_encoder
    import hle_pkg::*;
#(
    parameter int N_CH = 64
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_CH-1:0]        disc_lo_i,
    input  logic [N_CH-1:0]        disc_mid_i,
    input  logic [N_CH-1:0]        disc_hi_i,
    input  logic [N_CH-1:0]        mask_lo_i,
    input  logic [N_CH-1:0]        mask_mid_i,
    input  logic [N_CH-1:0]        mask_hi_i,
    input  logic                   chan_clr_i,
    input  logic                   evt_valid_i,
    output logic                   trig_lo_o,
    output logic                   trig_mid_o,
    output logic                   trig_hi_o,
    output logic [CODE_W*N_CH-1:0] hit_code_o,
    output logic [CODE_W*N_CH-1:0] held_code_o
);
    localparam int WORD_W = CODE_W * N_CH;

    logic [NUM_LVL-1:0][N_CH-1:0] armed_by_lvl;
    logic [NUM_LVL-1:0]           trig_vec;

    for (genvar c = 0; c < N_CH; c++) begin : g_chan
        lvl_t disc_c, mask_c, armed_c;

        // Gather this channel's level bits.
        always_comb begin
            disc_c = '{hi: disc_hi_i[c], mid: disc_mid_i[c], lo: disc_lo_i[c]};
            mask_c = '{hi: mask_hi_i[c], mid: mask_mid_i[c], lo: mask_lo_i[c]};
        end

        hle_chan u_chan (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (chan_clr_i),
            .disc  (disc_c),
            .mask  (mask_c),
            .armed (armed_c),
            .code  (hit_code_o[CODE_W*c +: CODE_W])
        );

        assign armed_by_lvl[0][c] = armed_c.lo;
        assign armed_by_lvl[1][c] = armed_c.mid;
        assign armed_by_lvl[2][c] = armed_c.hi;
    end

    for (genvar l = 0; l < NUM_LVL; l++) begin : g_trig
        hle_or_tree #(.WIDTH(N_CH)) u_or (
            .bits (armed_by_lvl[l]),
            .any  (trig_vec[l])
        );
    end

    assign trig_lo_o  = trig_vec[0];
    assign trig_mid_o = trig_vec[1];
    assign trig_hi_o  = trig_vec[2];

    hle_hold #(.W(WORD_W)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (evt_valid_i),
        .d     (hit_code_o),
        .q     (held_code_o)
    );
endmodule

// File: rtl/hle_checker.sv
// Protocol checks for hit_latch_encoder, attached by bind.
module hle_checker #(
    parameter int N_CH = 64
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [N_CH-1:0]      mask_lo_i,
    input logic [N_CH-1:0]      mask_mid_i,
    input logic [N_CH-1:0]      mask_hi_i,
    input logic                 chan_clr_i,
    input logic                 evt_valid_i,
    input logic                 trig_lo_o,
    input logic                 trig_mid_o,
    input logic                 trig_hi_o,
    input logic [2*N_CH-1:0]    hit_code_o,
    input logic [2*N_CH-1:0]    held_code_o
);
    a_r7_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        chan_clr_i |=> (hit_code_o == '0));

    a_r8_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid_i |=> (held_code_o == $past(hit_code_o)));

    a_r9_hold_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_valid_i |=> $stable(held_code_o));

    a_r4_all_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ((&mask_lo_i) |-> !trig_lo_o) and ((&mask_mid_i) |-> !trig_mid_o)
        and ((&mask_hi_i) |-> !trig_hi_o));

    for (genvar c = 0; c < N_CH; c++) begin : g_mono
        a_r2_code_never_drops: assert property (@(posedge clk) disable iff (!rst_n)
            !chan_clr_i |=> (hit_code_o[2*c +: 2] >= $past(hit_code_o[2*c +: 2])));
    end
endmodule

bind hit_latch_encoder hle_checker #(.N_CH(N_CH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mask_lo_i   (mask_lo_i),
    .mask_mid_i  (mask_mid_i),
    .mask_hi_i   (mask_hi_i),
    .chan_clr_i  (chan_clr_i),
    .evt_valid_i (evt_valid_i),
    .trig_lo_o   (trig_lo_o),
    .trig_mid_o  (trig_mid_o),
    .trig_hi_o   (trig_hi_o),
    .hit_code_o  (hit_code_o),
    .held_code_o (held_code_o)
);

// File: tb/hit_latch_encoder_tb.sv
`timescale 1ns/1ps
module hit_latch_encoder_tb;
    localparam int N = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] dlo = '0, dmid = '0, dhi = '0;
    logic [N-1:0] mlo = '0, mmid = '0, mhi = '0;
    logic clr = 1'b0, evt = 1'b0;
    logic tlo, tmid, thi;
    logic [2*N-1:0] code, held;

    int total = 0;
    int bad = 0;

    // Reference state: latched levels per channel, snapshot codes.
    bit lat_lo [N];
    bit lat_mid[N];
    bit lat_hi [N];
    int held_ref[N];

    always #2.5 clk = ~clk;

    hit_latch_encoder #(.N_CH(N)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .disc_lo_i(dlo), .disc_mid_i(dmid), .disc_hi_i(dhi),
        .mask_lo_i(mlo), .mask_mid_i(mmid), .mask_hi_i(mhi),
        .chan_clr_i(clr), .evt_valid_i(evt),
        .trig_lo_o(tlo), .trig_mid_o(tmid), .trig_hi_o(thi),
        .hit_code_o(code), .held_code_o(held)
    );

    function automatic int ref_code(int c);
        if (lat_hi[c])  return 3;
        if (lat_mid[c]) return 2;
        if (lat_lo[c])  return 1;
        return 0;
    endfunction

    task automatic check(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Apply inputs, check triggers, clock once, update model, check codes.
    task automatic step();
        bit elo, emid, ehi;
        @(negedge clk);
        #0.5;
        elo = 0; emid = 0; ehi = 0;
        for (int c = 0; c < N; c++) begin
            elo  |= dlo[c]  & !mlo[c];
            emid |= dmid[c] & !mmid[c];
            ehi  |= dhi[c]  & !mhi[c];
        end
        check("R5 R4 trig_lo",  tlo,  elo);
        check("R5 R4 trig_mid", tmid, emid);
        check("R5 R4 trig_hi",  thi,  ehi);
        @(posedge clk);
        for (int c = 0; c < N; c++) begin
            if (!rst_n) begin
                held_ref[c] = 0;
                lat_lo[c] = 0; lat_mid[c] = 0; lat_hi[c] = 0;
            end else begin
                if (evt) held_ref[c] = ref_code(c);
                if (clr) begin
                    lat_lo[c] = 0; lat_mid[c] = 0; lat_hi[c] = 0;
                end else begin
                    lat_lo[c]  |= dlo[c]  & !mlo[c];
                    lat_mid[c] |= dmid[c] & !mmid[c];
                    lat_hi[c]  |= dhi[c]  & !mhi[c];
                end
            end
        end
        #0.5;
        for (int c = 0; c < N; c++) begin
            check($sformatf("R2 R3 R6 R7 code ch%0d", c), int'(code[2*c +: 2]), ref_code(c));
            check($sformatf("R8 R9 held ch%0d", c), int'(held[2*c +: 2]), held_ref[c]);
        end
    endtask

    task automatic quiet();
        dlo = '0; dmid = '0; dhi = '0; clr = 0; evt = 0;
    endtask

    function automatic logic [N-1:0] sparse(int odds);
        logic [N-1:0] v;
        for (int i = 0; i < N; i++) v[i] = ($urandom_range(odds - 1) == 0);
        return v;
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        for (int c = 0; c < N; c++) begin
            lat_lo[c] = 0; lat_mid[c] = 0; lat_hi[c] = 0; held_ref[c] = 0;
        end
        // R1: reset with hits present must leave everything at zero.
        dlo = '1; dhi = '1; evt = 1;
        step(); step();
        check("R1 code after reset", int'(code == '0), 1);
        check("R1 held after reset", int'(held == '0), 1);
        rst_n = 1; quiet();
        step();

        // R6 / R2: single levels on chosen channels, then removal (sticky).
        dlo[3] = 1; dmid[5] = 1; dhi[N-1] = 1;
        step(); quiet(); step();
        check("R6 low only ch3", int'(code[7:6]), 1);
        check("R6 mid only ch5", int'(code[11:10]), 2);
        check("R6 high only ch63", int'(code[2*N-1 -: 2]), 3);
        // Climbing channel 0.
        dlo[0] = 1; step(); dlo[0] = 0; dmid[0] = 1; step(); quiet(); step();
        check("R2 R6 ch0 low+mid sticky", int'(code[1:0]), 2);

        // R3/R4: masked level never latches nor triggers.
        mlo[10] = 1; mhi[11] = 1; dlo[10] = 1; dhi[11] = 1;
        step(); quiet(); step();
        check("R3 masked low ch10", int'(code[21:20]), 0);
        check("R3 masked high ch11", int'(code[23:22]), 0);
        mlo = '1; mmid = '1; mhi = '1; dlo = '1; dmid = '1; dhi = '1;
        step();
        check("R4 all masked trig", int'({tlo, tmid, thi}), 0);
        mlo = '0; mmid = '0; mhi = '0; quiet();

        // R8 snapshot then R9 hold while codes change.
        evt = 1; step(); evt = 0;
        check("R8 snapshot ch5", int'(held[11:10]), 2);
        dhi[3] = 1; step(); quiet(); step();
        check("R9 held unchanged ch3", int'(held[7:6]), 1);

        // R7 with R8: clear, strobe and new hits in the same cycle.
        clr = 1; evt = 1; dhi[20] = 1; dlo = '1;
        step(); quiet(); step();
        check("R7 clear wins", int'(code == '0), 1);
        check("R8 pre-clear snapshot ch3", int'(held[7:6]), 3);

        // Random phase with frequent clears and strobes.
        for (int k = 0; k < 600; k++) begin
            dlo = sparse(16); dmid = sparse(32); dhi = sparse(64);
            mlo = sparse(8); mmid = sparse(8); mhi = sparse(8);
            clr = ($urandom_range(15) == 0);
            evt = ($urandom_range(3) == 0);
            step();
        end
        quiet();
        step();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule